// File: doc/BRIEF.md
# Serial Debug Wire Mode Detector

This block sits on the target side of a two-wire debug port and runs on the debug clock. On every rising edge it samples the shared mode/data line. From the bit history it works out which wire protocol is active: JTAG, the two-wire serial debug protocol (SWD) or a low-power dormant state. It recognises the long runs of high bits that reset either protocol, the 16-bit switching codes between JTAG and SWD, the two dormant-entry codes, and the 128-bit selection alert. It also decodes the protocol activation code that follows the alert.

The line is sampled on every clock edge and the block cannot stall it, so the input has no valid/ready handshake. There is no back-pressure: every sampled bit is consumed in the cycle it arrives. All three outputs are plain registered control levels. `mode_o` tells the SWD packet engine or the JTAG TAP which of them owns the line. `line_rst_o` is a one-cycle pulse for each completed SWD line reset. `swd_synced_o` shows whether a line reset has been seen since the interface last entered SWD. The packet engine should accept transactions only while `swd_synced_o` is high.

Every bit sequence is matched with the least significant bit arriving first. Each decision is taken on the clock edge that samples the last bit of its sequence.

Top module: `wire_mode_detector`

## Requirements
- R1: After reset, `mode_o` is 0 (JTAG), `line_rst_o` is 0 and `swd_synced_o` is 0. The mode encoding is 0 for JTAG, 1 for SWD and 2 for dormant.
- R2: In SWD mode, a run of at least 50 consecutive high samples followed by two low samples raises `line_rst_o` for exactly one cycle, in the cycle after the second low is sampled. A run of 49 high samples gives no pulse. The same stimulus in JTAG or dormant mode gives no pulse.
- R3: In JTAG mode, at least 50 high samples followed by the 16-bit code 0xE79E switch `mode_o` to SWD. The mode changes after the sixteenth code bit and not before.
- R4: In SWD mode, at least 50 high samples followed by the code 0xE73C switch `mode_o` to JTAG. With only 49 high samples before the code, the mode stays SWD.
- R5: In SWD mode, at least 50 high samples followed by the code 0xE3BC move `mode_o` to dormant.
- R6: In JTAG mode, at least 5 high samples followed by the 31-bit code 0x33BBBBBA move `mode_o` to dormant. With a run of only 4 high samples before the code, the mode stays JTAG.
- R7: In dormant mode, the selection alert is the 16 bytes 0x92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19. The bytes arrive in that order, each byte least significant bit first. The alert is recognised only when at least 8 high samples come right before it. After only 7 high samples the alert and any following activation code are ignored.
- R8: After a recognised alert, the line must be low for 4 samples and then carry an activation code. The 8-bit code 0x1A selects SWD. The 8-bit code 0x0A selects JTAG. Twelve zero bits select JTAG. After the first 8 of those zero bits the mode is still dormant.
- R9: `swd_synced_o` clears on every change of `mode_o` and sets when an SWD line reset completes (R2). After leaving dormant into SWD it stays low until a line reset.
- R10: An activation code that matches none of the R8 codes leaves the block dormant. A later low nibble and valid code without a fresh alert also leaves it dormant.
- R11: A high run far longer than 63 samples (the counter saturates) still counts as at least 50 high samples for R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Shared mode/data line as seen by the target |
| mode_o | output | 2 | Active protocol: 0 JTAG, 1 SWD, 2 dormant |
| line_rst_o | output | 1 | One-cycle pulse per completed SWD line reset |
| swd_synced_o | output | 1 | High once a line reset has completed in the current SWD session |

## Verification
Every result is due one clock edge after its final input bit is sampled. A mode switch shows on `mode_o` right after the edge that samples the last bit of a code, and a line-reset pulse shows right after the edge that samples the second low. The bench drives each bit just after a falling edge. It compares the outputs shortly after the falling edge that follows the sampling edge, so every check lands in the first cycle the result is valid. Where a result must not come early, the bench checks before the final bit too: the last switching-code bit and the ambiguous zero activation byte. Pulses are counted once per cycle at the falling edge, and the bench also checks that the pulse has dropped one cycle later.

// File: rtl/wmd_pkg.sv
package wmd_pkg;

  typedef enum logic [1:0] {
    MODE_JTAG = 2'd0,
    MODE_SWD  = 2'd1,
    MODE_DORM = 2'd2
  } wire_mode_e;

  typedef enum logic {
    DS_HUNT = 1'b0,
    DS_ACT  = 1'b1
  } dorm_sub_e;

  localparam int SW_LEN     = 16;
  localparam int J2D_LEN    = 31;
  localparam int ALERT_LEN  = 128;
  localparam int ACT_LOW_W  = 4;
  localparam int ACT_BYTE_W = 8;
  localparam int ACT_SER_W  = 12;

  localparam logic [SW_LEN-1:0]    CODE_J2S = 16'hE79E;
  localparam logic [SW_LEN-1:0]    CODE_S2J = 16'hE73C;
  localparam logic [SW_LEN-1:0]    CODE_S2D = 16'hE3BC;
  localparam logic [J2D_LEN-1:0]   CODE_J2D = 31'h33BBBBBA;
  localparam logic [ALERT_LEN-1:0] ALERT_SEQ =
    128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
  localparam logic [ACT_BYTE_W-1:0] ACT_SWD = 8'h1A;
  localparam logic [ACT_BYTE_W-1:0] ACT_JDP = 8'h0A;

endpackage

// File: rtl/wmd_line_history.sv
module wmd_line_history #(
  parameter int HI_SAT    = 63,
  parameter int HI_W      = 6,
  parameter int WIN_W     = 128,
  parameter int POS_W     = 8,
  parameter int LONG_HIGH = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [HI_W-1:0]  thr_i,
  output logic [WIN_W-1:0] win_nxt_o,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic             long_nxt_o
);

  localparam logic [HI_W-1:0]  HI_MAX  = HI_W'(HI_SAT);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [WIN_W-1:0] win_q;
  logic [HI_W-1:0]  hi_q;
  logic [POS_W-1:0] pos_q;
  logic             long_q;
  logic             restart;

  // newest bit enters at the top, so a code of N bits sits in the top N bits
  assign win_nxt_o  = {line_i, win_q[WIN_W-1:1]};
  // a low bit ending a long enough high run opens a new candidate code
  assign restart    = !line_i && (hi_q >= thr_i);
  assign pos_nxt_o  = restart ? POS_W'(1)
                    : ((pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1);
  assign long_nxt_o = restart ? (hi_q >= HI_W'(LONG_HIGH)) : long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      hi_q   <= '0;
      pos_q  <= POS_MAX;
      long_q <= 1'b0;
    end else begin
      win_q  <= win_nxt_o;
      pos_q  <= pos_nxt_o;
      long_q <= long_nxt_o;
      if (!line_i)              hi_q <= '0;
      else if (hi_q != HI_MAX)  hi_q <= hi_q + 1'b1;
    end
  end

  // R11
  pos_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(1)) |-> !win_q[WIN_W-1]);

  // R11
  hi_sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && hi_q == HI_MAX) |=> (hi_q == HI_MAX));

endmodule

// File: rtl/wmd_pattern_match.sv
module wmd_pattern_match
  import wmd_pkg::*;
#(
  parameter int WIN_W = 128,
  parameter int POS_W = 8
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             long_i,
  output logic             hit_j2s_o,
  output logic             hit_s2j_o,
  output logic             hit_s2d_o,
  output logic             hit_j2d_o,
  output logic             hit_alert_o,
  output logic             hit_lrst_o,
  output logic             act_swd_o,
  output logic             act_jdp_o,
  output logic             act_zero8_o,
  output logic             act_zero16_o
);

  localparam int ACT_ALL_W = ACT_LOW_W + ACT_SER_W;

  logic [SW_LEN-1:0]     sw_field;
  logic [ACT_BYTE_W-1:0] code8;
  logic [ACT_LOW_W-1:0]  lows;
  logic                  pos_sw;

  assign sw_field = win_i[WIN_W-1 -: SW_LEN];
  assign code8    = win_i[WIN_W-1 -: ACT_BYTE_W];
  assign lows     = win_i[WIN_W-1-ACT_BYTE_W -: ACT_LOW_W];
  assign pos_sw   = long_i && (pos_i == POS_W'(SW_LEN));

  assign hit_j2s_o   = pos_sw && (sw_field == CODE_J2S);
  assign hit_s2j_o   = pos_sw && (sw_field == CODE_S2J);
  assign hit_s2d_o   = pos_sw && (sw_field == CODE_S2D);
  assign hit_j2d_o   = (pos_i == POS_W'(J2D_LEN)) &&
                       (win_i[WIN_W-1 -: J2D_LEN] == CODE_J2D);
  assign hit_alert_o = (pos_i == POS_W'(ALERT_LEN)) &&
                       (win_i[WIN_W-1 -: ALERT_LEN] == ALERT_SEQ);
  assign hit_lrst_o  = long_i && (pos_i == POS_W'(2)) &&
                       (win_i[WIN_W-1 -: 2] == 2'b00);

  assign act_swd_o    = (lows == '0) && (code8 == ACT_SWD);
  assign act_jdp_o    = (lows == '0) && (code8 == ACT_JDP);
  assign act_zero8_o  = (lows == '0) && (code8 == '0);
  assign act_zero16_o = (win_i[WIN_W-1 -: ACT_ALL_W] == '0);

endmodule

// File: rtl/wmd_mode_fsm.sv
module wmd_mode_fsm
  import wmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_j2s_i,
  input  logic       hit_s2j_i,
  input  logic       hit_s2d_i,
  input  logic       hit_j2d_i,
  input  logic       hit_alert_i,
  input  logic       hit_lrst_i,
  input  logic       act_swd_i,
  input  logic       act_jdp_i,
  input  logic       act_zero8_i,
  input  logic       act_zero16_i,
  output wire_mode_e mode_o,
  output logic       line_rst_o,
  output logic       synced_o
);

  localparam int ACT_SHORT = ACT_LOW_W + ACT_BYTE_W;
  localparam int ACT_LONG  = ACT_LOW_W + ACT_SER_W;
  localparam int ACT_W     = $clog2(ACT_LONG + 1);

  wire_mode_e       mode_q, mode_d;
  dorm_sub_e        sub_q, sub_d;
  logic [ACT_W-1:0] act_q, act_d, act_nxt;
  logic             lrst_q, lrst_d;
  logic             synced_q, synced_d;

  assign act_nxt = act_q + 1'b1;

  always_comb begin
    mode_d = mode_q;
    sub_d  = sub_q;
    act_d  = act_q;
    unique case (mode_q)
      MODE_JTAG: begin
        if (hit_j2s_i) begin
          mode_d = MODE_SWD;
        end else if (hit_j2d_i) begin
          mode_d = MODE_DORM;
          sub_d  = DS_HUNT;
        end
      end
      MODE_SWD: begin
        if (hit_s2j_i) begin
          mode_d = MODE_JTAG;
        end else if (hit_s2d_i) begin
          mode_d = MODE_DORM;
          sub_d  = DS_HUNT;
        end
      end
      MODE_DORM: begin
        if (sub_q == DS_HUNT) begin
          if (hit_alert_i) begin
            sub_d = DS_ACT;
            act_d = '0;
          end
        end else begin
          act_d = act_nxt;
          if (act_nxt == ACT_W'(ACT_SHORT)) begin
            if (act_swd_i) begin
              mode_d = MODE_SWD;
              sub_d  = DS_HUNT;
            end else if (act_jdp_i) begin
              mode_d = MODE_JTAG;
              sub_d  = DS_HUNT;
            end else if (!act_zero8_i) begin
              sub_d  = DS_HUNT;
            end
          end else if (act_nxt == ACT_W'(ACT_LONG)) begin
            sub_d = DS_HUNT;
            if (act_zero16_i) mode_d = MODE_JTAG;
          end
        end
      end
      default: begin
        mode_d = MODE_JTAG;
        sub_d  = DS_HUNT;
      end
    endcase
  end

  assign lrst_d   = (mode_q == MODE_SWD) && hit_lrst_i;
  assign synced_d = (mode_d != mode_q) ? 1'b0 : (lrst_d ? 1'b1 : synced_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_JTAG;
      sub_q    <= DS_HUNT;
      act_q    <= '0;
      lrst_q   <= 1'b0;
      synced_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      sub_q    <= sub_d;
      act_q    <= act_d;
      lrst_q   <= lrst_d;
      synced_q <= synced_d;
    end
  end

  assign mode_o     = mode_q;
  assign line_rst_o = lrst_q;
  assign synced_o   = synced_q;

  // R1
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);

  // R2
  lrst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_q |=> !lrst_q);

  // R2
  lrst_swd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_q |-> (mode_q == MODE_SWD));

  // R9
  synced_by_lrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synced_q) |-> lrst_q);

  // R9
  dorm_exit_unsynced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SWD && $past(mode_q) == MODE_DORM) |-> !synced_q);

  // R7
  act_in_dorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q == DS_ACT) |-> (mode_q == MODE_DORM));

endmodule

// File: rtl/wire_mode_detector.sv
module wire_mode_detector
  import wmd_pkg::*;
#(
  parameter int LONG_HIGH      = 50,
  parameter int JTAG_PRE_HIGH  = 5,
  parameter int ALERT_PRE_HIGH = 8,
  parameter int HI_SAT         = 63
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic [1:0] mode_o,
  output logic       line_rst_o,
  output logic       swd_synced_o
);

  localparam int HI_W  = $clog2(HI_SAT + 1);
  localparam int WIN_W = ALERT_LEN;
  localparam int POS_W = $clog2(ALERT_LEN + 1);

  wire_mode_e       mode;
  logic [HI_W-1:0]  thr;
  logic [WIN_W-1:0] win_nxt;
  logic [POS_W-1:0] pos_nxt;
  logic             long_nxt;
  logic hit_j2s, hit_s2j, hit_s2d, hit_j2d, hit_alert, hit_lrst;
  logic act_swd, act_jdp, act_zero8, act_zero16;

  assign thr = (mode == MODE_DORM) ? HI_W'(ALERT_PRE_HIGH) : HI_W'(JTAG_PRE_HIGH);

  wmd_line_history #(
    .HI_SAT(HI_SAT), .HI_W(HI_W), .WIN_W(WIN_W),
    .POS_W(POS_W), .LONG_HIGH(LONG_HIGH)
  ) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .thr_i(thr),
    .win_nxt_o(win_nxt), .pos_nxt_o(pos_nxt), .long_nxt_o(long_nxt)
  );

  wmd_pattern_match #(.WIN_W(WIN_W), .POS_W(POS_W)) u_match (
    .win_i(win_nxt), .pos_i(pos_nxt), .long_i(long_nxt),
    .hit_j2s_o(hit_j2s), .hit_s2j_o(hit_s2j), .hit_s2d_o(hit_s2d),
    .hit_j2d_o(hit_j2d), .hit_alert_o(hit_alert), .hit_lrst_o(hit_lrst),
    .act_swd_o(act_swd), .act_jdp_o(act_jdp),
    .act_zero8_o(act_zero8), .act_zero16_o(act_zero16)
  );

  wmd_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_j2s_i(hit_j2s), .hit_s2j_i(hit_s2j), .hit_s2d_i(hit_s2d),
    .hit_j2d_i(hit_j2d), .hit_alert_i(hit_alert), .hit_lrst_i(hit_lrst),
    .act_swd_i(act_swd), .act_jdp_i(act_jdp),
    .act_zero8_i(act_zero8), .act_zero16_i(act_zero16),
    .mode_o(mode), .line_rst_o(line_rst_o), .synced_o(swd_synced_o)
  );

  assign mode_o = mode;

endmodule

// File: tb/wire_mode_detector_bench.sv
module wire_mode_detector_bench;

  localparam int CLK_P = 10;
  localparam int M_JTAG = 0;
  localparam int M_SWD  = 1;
  localparam int M_DORM = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_r = 1'b0;
  logic [1:0] mode;
  logic       lrst;
  logic       synced;

  int nchk = 0;
  int nfail = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wire_mode_detector u_wire_mode_detector (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_r),
    .mode_o(mode), .line_rst_o(lrst), .swd_synced_o(synced)
  );

  always @(negedge clk) if (rst_n && lrst) pulses++;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // entered just after a falling edge; returns just after the next one
  task automatic send_bit(input logic b);
    line_r = b;
    @(negedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_alert();
    logic [7:0] bytes [16] = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D,
                               8'h85, 8'h86, 8'hE9, 8'hAF, 8'hDD, 8'hE3,
                               8'hA2, 8'h0E, 8'hBC, 8'h19};
    for (int k = 0; k < 16; k++) send_bits(64'(bytes[k]), 8);
  endtask

  task automatic t_reset();
    check("R1 mode", mode, M_JTAG);
    check("R1 line_rst", lrst, 0);
    check("R1 synced", synced, 0);
  endtask

  task automatic t_jtag_no_pulse();
    send_run(1'b1, 60); send_run(1'b0, 2);
    check("R2 no pulse in JTAG", pulses, exp_pulses);
    check("R2 mode JTAG", mode, M_JTAG);
  endtask

  task automatic t_jtag_to_swd();
    send_run(1'b1, 60);
    send_bits(64'hE79E, 15);
    check("R3 not before last bit", mode, M_JTAG);
    send_bit(1'b1);  // bit 15 of 0xE79E
    check("R3 JTAG to SWD", mode, M_SWD);
    check("R9 unsynced on entry", synced, 0);
  endtask

  task automatic t_line_reset();
    send_run(1'b0, 2); send_run(1'b1, 49); send_run(1'b0, 2);
    check("R2 49 highs no pulse", pulses, exp_pulses);
    send_run(1'b1, 50); send_bit(1'b0);
    check("R2 one low not yet", lrst, 0);
    send_bit(1'b0);
    exp_pulses++;
    check("R2 pulse high", lrst, 1);
    check("R2 pulse count", pulses, exp_pulses);
    check("R9 synced set", synced, 1);
    send_bit(1'b0);
    check("R2 pulse one cycle", lrst, 0);
  endtask

  task automatic t_swd_short_prefix();
    send_run(1'b0, 5); send_run(1'b1, 49); send_bits(64'hE73C, 16);
    check("R4 49 highs keeps SWD", mode, M_SWD);
    check("R2 no pulse short", pulses, exp_pulses);
  endtask

  task automatic t_swd_to_jtag();
    send_run(1'b1, 50); send_bits(64'hE73C, 16);
    exp_pulses++;  // code begins with two lows: line reset completes
    check("R4 SWD to JTAG", mode, M_JTAG);
    check("R2 prefix pulse", pulses, exp_pulses);
    check("R9 cleared on exit", synced, 0);
    send_run(1'b1, 5);
    check("R4 stays JTAG", mode, M_JTAG);
  endtask

  task automatic t_jtag_short_prefix();
    send_run(1'b0, 40); send_run(1'b1, 4); send_bits(64'h33BBBBBA, 31);
    check("R6 4 highs keeps JTAG", mode, M_JTAG);
  endtask

  task automatic t_jtag_to_dorm();
    send_run(1'b1, 5); send_bits(64'h33BBBBBA, 31);
    check("R6 JTAG to dormant", mode, M_DORM);
  endtask

  task automatic t_alert_short_prefix();
    send_run(1'b0, 100); send_run(1'b1, 7); send_alert();
    send_run(1'b0, 4); send_bits(64'h1A, 8);
    check("R7 7 highs ignored", mode, M_DORM);
  endtask

  task automatic t_bad_activation();
    send_run(1'b1, 8); send_alert(); send_run(1'b0, 4); send_bits(64'h55, 8);
    check("R10 bad code stays dormant", mode, M_DORM);
    send_run(1'b0, 4); send_bits(64'h1A, 8);
    check("R10 no fresh alert", mode, M_DORM);
  endtask

  task automatic t_act_swd();
    send_run(1'b1, 8); send_alert(); send_run(1'b0, 4); send_bits(64'h1A, 7);
    check("R8 not before last bit", mode, M_DORM);
    send_bit(1'b0);
    check("R8 SWD activation", mode, M_SWD);
    check("R9 unsynced after dormant", synced, 0);
    send_run(1'b1, 58); send_run(1'b0, 2);
    exp_pulses++;
    check("R9 line reset after activation", pulses, exp_pulses);
    check("R9 synced after reset", synced, 1);
  endtask

  task automatic t_swd_to_dorm();
    send_run(1'b1, 50); send_bits(64'hE3BC, 16);
    exp_pulses++;
    check("R5 SWD to dormant", mode, M_DORM);
    check("R5 prefix pulse", pulses, exp_pulses);
    check("R9 cleared in dormant", synced, 0);
  endtask

  task automatic t_act_jdp();
    send_run(1'b1, 8); send_alert(); send_run(1'b0, 4); send_bits(64'h0A, 8);
    check("R8 JTAG variant activation", mode, M_JTAG);
  endtask

  task automatic t_act_serial();
    send_run(1'b1, 5); send_bits(64'h33BBBBBA, 31);
    check("R6 back to dormant", mode, M_DORM);
    send_run(1'b1, 8); send_alert(); send_run(1'b0, 4); send_run(1'b0, 8);
    check("R8 zero byte still dormant", mode, M_DORM);
    send_run(1'b0, 4);
    check("R8 twelve zeros select JTAG", mode, M_JTAG);
  endtask

  task automatic t_long_run();
    send_run(1'b1, 200); send_bits(64'hE79E, 16);
    check("R11 long run JTAG to SWD", mode, M_SWD);
    send_run(1'b1, 200); send_run(1'b0, 2);
    exp_pulses++;
    check("R11 long run line reset", pulses, exp_pulses);
    check("R11 synced", synced, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_jtag_no_pulse();
    t_jtag_to_swd();
    t_line_reset();
    t_swd_short_prefix();
    t_swd_to_jtag();
    t_jtag_short_prefix();
    t_jtag_to_dorm();
    t_alert_short_prefix();
    t_bad_activation();
    t_act_swd();
    t_swd_to_dorm();
    t_act_jdp();
    t_act_serial();
    t_long_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule